// File: doc/BRIEF.md
# Per-Block Memory Access Permission Checker

This block sits in front of a 512 KB memory and judges every access against a policy kept for each 2 KB block. There are 256 blocks. Each block has two policy bits. The modify bit allows program and erase. The data-read bit allows data reads. The bits for each kind are packed into eight 32-bit registers, so there are two bitmaps. A configuration bus writes these registers and can read them back. Bits can only ever be cleared, and only a full reset sets them again.

An access request carries an address, an access kind and the word the memory returns. The verdict comes back one cycle later. It is either a grant or a deny, with the read data passed through or forced to zero, and a gated enable that the memory uses to modify its contents.

Instruction fetch is always granted, so a block with both bits clear can still run code while refusing every data read, including a debugger read. The first denied access is latched into a sticky fault record that holds its block number and access kind.

Top module: `blkperm_guard`

## Requirements
- R1: After reset every policy bit in both bitmaps reads 1, the fault record is empty, and both grant and deny are low.
- R2: The block number is address bits [18:11]. Block `b` maps to register `b/32`, bit `b%32`, of each bitmap.
- R3: An access of kind 0 (instruction fetch) is granted whatever the two policy bits of its block hold.
- R4: An access of kind 1 (data read) is granted only when the block's data-read bit is 1, and is denied otherwise.
- R5: An access of kind 2 (program) or kind 3 (erase) is granted only when the block's modify bit is 1, and is denied otherwise.
- R6: A configuration write selects the modify bitmap with select 0 and the data-read bitmap with select 1. It ANDs the written word into the addressed register, so a 0 clears a bit and a 1 leaves it unchanged.
- R7: The grant and deny outputs answer the request made in the previous cycle. They are never high together, and both are low in the cycle after a cycle with no request.
- R8: A denied access returns read data of zero and leaves the memory modify enable low.
- R9: A granted fetch or data read returns the memory word registered by one cycle. A granted program or erase raises the memory modify enable for that one cycle.
- R10: The first denied access after reset sets the fault flag and records its block number and access kind. The record then holds unchanged, through later denials, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Policy register write strobe |
| cfg_sel | input | 1 | Bitmap select: 0 modify, 1 data-read |
| cfg_idx | input | 3 | Policy register index |
| cfg_wdata | input | 32 | Word ANDed into the selected register |
| cfg_rdata | output | 32 | Current value of the selected register |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | 19 | Byte address of the access |
| acc_type | input | 2 | Access kind: 0 fetch, 1 read, 2 program, 3 erase |
| mem_rdata | input | 32 | Word returned by the memory for this access |
| acc_grant | output | 1 | Previous request granted |
| acc_deny | output | 1 | Previous request denied |
| acc_rdata | output | 32 | Registered read data, zero unless a granted fetch or read |
| mem_mod_en | output | 1 | Memory may apply the previous program or erase |
| flt_valid | output | 1 | Sticky fault flag |
| flt_block | output | 8 | Block number of the first denied access |
| flt_type | output | 2 | Access kind of the first denied access |

## Verification
The assertions assume that reset is held for at least one clock edge before any request. They also assume that `acc_type` is a defined two-bit code whenever `acc_valid` is high. The bench meets both assumptions: it holds reset for several cycles and drives every request with a known kind. Requests go in back-to-back across all 256 blocks and all four kinds. Policy writes are kept apart from the access sweep, so no decision sees a bitmap changing in the same cycle.

// File: rtl/blkperm_pkg.sv
package blkperm_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_PROG  = 2'd2,
        ACC_ERASE = 2'd3
    } acc_kind_e;

    function automatic logic kind_allowed(acc_kind_e kind, logic mod_bit, logic rd_bit);
        logic ok;
        case (kind)
            ACC_FETCH: ok = 1'b1;
            ACC_READ:  ok = rd_bit;
            default:   ok = mod_bit;
        endcase
        return ok;
    endfunction

    function automatic logic kind_modifies(acc_kind_e kind);
        return (kind == ACC_PROG) || (kind == ACC_ERASE);
    endfunction

endpackage

// File: rtl/blkperm_policy.sv
module blkperm_policy #(
    parameter int REG_W = 32,
    parameter int NREGS = 8,
    localparam int NBLK  = REG_W * NREGS,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic [NBLK-1:0]  mod_map,
    output logic [NBLK-1:0]  rd_map
);

    logic [REG_W-1:0] mod_r [NREGS];
    logic [REG_W-1:0] rd_r  [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                mod_r[i] <= '1;
                rd_r[i]  <= '1;
            end else if (cfg_we && (cfg_idx == IDX_W'(i))) begin
                if (cfg_sel) rd_r[i]  <= rd_r[i]  & cfg_wdata;
                else         mod_r[i] <= mod_r[i] & cfg_wdata;
            end
        end

        assign mod_map[i*REG_W +: REG_W] = mod_r[i];
        assign rd_map[i*REG_W +: REG_W]  = rd_r[i];

        // R6: a policy bit never goes from 0 back to 1 outside reset
        p_bits_only_fall_r6 : assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (((mod_r[i] & ~$past(mod_r[i])) == '0) &&
                      ((rd_r[i]  & ~$past(rd_r[i]))  == '0)));
    end

    assign cfg_rdata = cfg_sel ? rd_r[cfg_idx] : mod_r[cfg_idx];

endmodule

// File: rtl/blkperm_decode.sv
module blkperm_decode #(
    parameter int BLK_W = 8,
    localparam int NBLK = 1 << BLK_W
) (
    input  logic [BLK_W-1:0] blk_addr,
    input  logic [NBLK-1:0]  mod_map,
    input  logic [NBLK-1:0]  rd_map,
    output logic [BLK_W-1:0] blk_num,
    output logic             mod_bit,
    output logic             rd_bit
);

    assign blk_num = blk_addr;
    assign mod_bit = mod_map[blk_addr];
    assign rd_bit  = rd_map[blk_addr];

endmodule

// File: rtl/blkperm_decide.sv
module blkperm_decide
    import blkperm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  acc_kind_e         acc_kind,
    input  logic              mod_bit,
    input  logic              rd_bit,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              deny_now,
    output logic              grant_q,
    output logic              deny_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              mod_en_q
);

    logic ok;

    assign ok       = kind_allowed(acc_kind, mod_bit, rd_bit);
    assign deny_now = acc_valid && !ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q  <= 1'b0;
            deny_q   <= 1'b0;
            rdata_q  <= '0;
            mod_en_q <= 1'b0;
        end else begin
            grant_q  <= acc_valid && ok;
            deny_q   <= deny_now;
            rdata_q  <= (acc_valid && ok && !kind_modifies(acc_kind)) ? mem_rdata : '0;
            mod_en_q <= acc_valid && ok && kind_modifies(acc_kind);
        end
    end

    // R3: fetch requests are always granted one cycle later
    p_fetch_granted_r3 : assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_kind == ACC_FETCH) |=> grant_q);

    // R7: grant and deny never coincide
    p_verdict_exclusive_r7 : assert property (@(posedge clk) disable iff (rst)
        !(grant_q && deny_q));

    // R7: no request gives no verdict
    p_idle_quiet_r7 : assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!grant_q && !deny_q));

endmodule

// File: rtl/blkperm_fault.sv
module blkperm_fault
    import blkperm_pkg::*;
#(
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             deny_now,
    input  logic [BLK_W-1:0] blk_num,
    input  acc_kind_e        acc_kind,
    output logic             flt_valid,
    output logic [BLK_W-1:0] flt_block,
    output acc_kind_e        flt_kind
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_valid <= 1'b0;
            flt_block <= '0;
            flt_kind  <= ACC_FETCH;
        end else if (deny_now && !flt_valid) begin
            flt_valid <= 1'b1;
            flt_block <= blk_num;
            flt_kind  <= acc_kind;
        end
    end

    // R10: the fault record is sticky and frozen once set
    p_fault_sticky_r10 : assert property (@(posedge clk) disable iff (rst)
        flt_valid |=> (flt_valid && $stable(flt_block) && $stable(flt_kind)));

endmodule

// File: rtl/blkperm_guard.sv
module blkperm_guard
    import blkperm_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int BLK_LOG2 = 11,
    parameter int REG_W    = 32,
    parameter int NREGS    = 8,
    parameter int DATA_W   = 32,
    localparam int NBLK    = REG_W * NREGS,
    localparam int BLK_W   = $clog2(NBLK),
    localparam int IDX_W   = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_type,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              acc_grant,
    output logic              acc_deny,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              mem_mod_en,
    output logic              flt_valid,
    output logic [BLK_W-1:0]  flt_block,
    output logic [1:0]        flt_type
);

    logic [NBLK-1:0]  mod_map;
    logic [NBLK-1:0]  rd_map;
    logic [BLK_W-1:0] blk_num;
    logic             mod_bit;
    logic             rd_bit;
    logic             deny_now;
    acc_kind_e        kind;
    acc_kind_e        flt_kind;

    assign kind = acc_kind_e'(acc_type);

    blkperm_policy #(.REG_W(REG_W), .NREGS(NREGS)) u_policy (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .mod_map   (mod_map),
        .rd_map    (rd_map)
    );

    blkperm_decode #(.BLK_W(BLK_W)) u_decode (
        .blk_addr (acc_addr[BLK_LOG2 +: BLK_W]),
        .mod_map  (mod_map),
        .rd_map   (rd_map),
        .blk_num  (blk_num),
        .mod_bit  (mod_bit),
        .rd_bit   (rd_bit)
    );

    blkperm_decide #(.DATA_W(DATA_W)) u_decide (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_kind  (kind),
        .mod_bit   (mod_bit),
        .rd_bit    (rd_bit),
        .mem_rdata (mem_rdata),
        .deny_now  (deny_now),
        .grant_q   (acc_grant),
        .deny_q    (acc_deny),
        .rdata_q   (acc_rdata),
        .mod_en_q  (mem_mod_en)
    );

    blkperm_fault #(.BLK_W(BLK_W)) u_fault (
        .clk       (clk),
        .rst       (rst),
        .deny_now  (deny_now),
        .blk_num   (blk_num),
        .acc_kind  (kind),
        .flt_valid (flt_valid),
        .flt_block (flt_block),
        .flt_kind  (flt_kind)
    );

    assign flt_type = flt_kind;

    // R8: a denial leaks no data and allows no modification
    p_deny_blocks_r8 : assert property (@(posedge clk) disable iff (rst)
        acc_deny |-> (acc_rdata == '0 && !mem_mod_en));

    // R9: the memory is modified only under a grant
    p_modify_needs_grant_r9 : assert property (@(posedge clk) disable iff (rst)
        mem_mod_en |-> acc_grant);

    // R10: a denial always leaves a fault record behind
    p_deny_logs_r10 : assert property (@(posedge clk) disable iff (rst)
        acc_deny |-> flt_valid);

endmodule

// File: tb/blkperm_guard_bench.sv
`timescale 1ns/1ps
module blkperm_guard_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic        cfg_sel;
    logic [2:0]  cfg_idx;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        acc_valid;
    logic [18:0] acc_addr;
    logic [1:0]  acc_type;
    logic [31:0] mem_rdata;
    logic        acc_grant;
    logic        acc_deny;
    logic [31:0] acc_rdata;
    logic        mem_mod_en;
    logic        flt_valid;
    logic [7:0]  flt_block;
    logic [1:0]  flt_type;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    blkperm_guard u_blkperm_guard (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_type(acc_type),
        .mem_rdata(mem_rdata), .acc_grant(acc_grant), .acc_deny(acc_deny),
        .acc_rdata(acc_rdata), .mem_mod_en(mem_mod_en),
        .flt_valid(flt_valid), .flt_block(flt_block), .flt_type(flt_type)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // policy pattern: modify bit cleared when block%3==0, read bit when block%5==0
    function automatic logic [31:0] pattern(bit sel, int idx);
        logic [31:0] w;
        for (int b = 0; b < 32; b++) begin
            int blk = idx * 32 + b;
            w[b] = sel ? (blk % 5 != 0) : (blk % 3 != 0);
        end
        return w;
    endfunction

    task automatic cfg_write(bit sel, int idx, logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = 3'(idx); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic check_regs(string req, bit patterned);
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                cfg_sel = s[0]; cfg_idx = 3'(i);
                #1;
                check(req, 64'(cfg_rdata), patterned ? 64'(pattern(s[0], i)) : 64'hFFFF_FFFF);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; acc_valid = 1'b0; cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_idx = '0; cfg_wdata = '0;
        acc_valid = 1'b0; acc_addr = '0; acc_type = '0; mem_rdata = '0;
        do_reset();

        // R1: reset state
        @(negedge clk);
        check("R1", {61'b0, acc_grant, acc_deny, flt_valid}, 64'd0);
        check_regs("R1", 1'b0);

        // R6: clear bits, then write all ones which must change nothing
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 8; i++) cfg_write(s[0], i, pattern(s[0], i));
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 8; i++) cfg_write(s[0], i, 32'hFFFF_FFFF);
        check_regs("R6", 1'b1);

        // R2 R3 R4 R5 R7 R8 R9: back-to-back sweep of every block and kind
        for (int blk = 0; blk < 256; blk++) begin
            for (int t = 0; t < 4; t++) begin
                bit mb, rb, g;
                logic [31:0] md;
                string req;
                mb = (blk % 3 != 0);
                rb = (blk % 5 != 0);
                g  = (t == 0) || (t == 1 && rb) || (t >= 2 && mb);
                md = 32'hA500_0000 | 32'(blk << 4) | 32'(t);
                req = (t == 0) ? "R3" : (t == 1) ? "R4" : "R5";
                @(negedge clk);
                acc_valid = 1'b1;
                acc_addr  = {8'(blk), 11'((blk * 37 + t * 5) % 2048)};
                acc_type  = 2'(t);
                mem_rdata = md;
                @(posedge clk);
                #1;
                check(req, {29'b0, acc_grant, acc_deny, mem_mod_en, acc_rdata},
                      {29'b0, g, !g, g && (t >= 2),
                       (g && t < 2) ? md : 32'd0});
            end
        end
        @(negedge clk);
        acc_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R7", {62'b0, acc_grant, acc_deny}, 64'd0);

        // R10: first denial was block 0, data read
        check("R10", {53'b0, flt_valid, flt_block, flt_type}, {53'b0, 1'b1, 8'd0, 2'd1});

        // R2: top of the address space, block 255 (mod bit 0, read bit 0)
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 19'h7FFFF; acc_type = 2'd2; mem_rdata = 32'h1234;
        @(posedge clk);
        #1;
        check("R2", {62'b0, acc_grant, acc_deny}, {62'b0, 1'b0, 1'b1});
        check("R10", {53'b0, flt_valid, flt_block, flt_type}, {53'b0, 1'b1, 8'd0, 2'd1});
        @(negedge clk);
        acc_valid = 1'b0;

        // R1: reset restores all bits and clears the fault record
        do_reset();
        @(negedge clk);
        check("R1", {61'b0, acc_grant, acc_deny, flt_valid}, 64'd0);
        check_regs("R1", 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule